// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous static memory with a two-stage pipeline. Every rising clock edge is classified as one of six cycle kinds: idle, deselect, read start, write start, burst step or burst hold. Two address strobes can open a burst. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write enables sampled on that same edge. Three chip enables decide whether an opened cycle reaches the array or only turns the part off. The master enable gates only the processor-side strobe.

The storage is four byte lanes of eight bits. Writes are byte-granular: a global write enable writes the whole word, and per-byte strobes take effect when a byte-write enable is active. An address sampled on one edge reads the array on the next edge. The data is then held in an output register, and a drive flag qualifies it. An asynchronous output enable gates the drive flag. After a burst opens, the low two address bits are stepped by a burst sequencer. It counts either linearly or with an exclusive-or pattern, and the order is chosen when the burst opens.

Top module: `psram_cyc_ctl`

## Requirements
- R1: An edge with `strb_proc_n`=0, `ce_main_n`=0, `ce_hi`=1 and `ce_lo_n`=0 opens a read at `addr_i`. On that edge `gwr_n`, `bwr_en_n`, `bstrb_n` and `strb_ctrl_n` are ignored, and the array is not written.
- R2: An edge with `strb_ctrl_n`=0 opens a cycle only if the processor strobe does not open one on that edge. Its write enables are sampled on that edge. A nonzero lane mask makes it a write start, and a zero mask makes it a read start.
- R3: When `ce_main_n`=1, `strb_proc_n`=0 opens nothing. `strb_ctrl_n`=0 is still accepted, but it becomes a deselect: no array write, and no drive afterwards.
- R4: An accepted strobe while `ce_hi`=0 or `ce_lo_n`=1 is a deselect. No array access is made.
- R5: When `gwr_n`=0, all four lanes are written, whatever `bstrb_n` and `bwr_en_n` are.
- R6: When `gwr_n`=1 and `bwr_en_n`=0, lane i (bits 8i+7..8i) is written exactly when `bstrb_n[i]`=0. When `gwr_n`=1 and `bwr_en_n`=1, nothing is written and the cycle is a read.
- R7: When `gwr_n`=1, `bwr_en_n`=0 and `bstrb_n`=4'hF, the cycle is a read.
- R8: Data for a read access made on edge k is on `rdata_o`, with `drive_o`=1, after edge k+1, as long as no write is sampled on edge k+1 and `oe_n`=0.
- R9: `oe_n`=1 forces `drive_o`=0 at once, without waiting for a clock. `rdata_o` is zero whenever `drive_o`=0.
- R10: An edge on which a write is performed clears `drive_o` after that edge, even with `oe_n`=0.
- R11: After a deselect on edge k, `drive_o` is 0 after edge k+1. Drive from a read made on edge k-1 still appears after edge k.
- R12: During an open burst, an edge with no strobe and `adv_n`=0 steps the burst count n (0..3, wrapping) and accesses the next address. The upper address bits stay fixed. The low bits are (b+n) mod 4 when the burst was opened with `seq_linear`=1, and b XOR n when it was opened with `seq_linear`=0, where b is the base low bits.
- R13: An edge with no strobe and `adv_n`=1 during an open burst holds the current address. The burst order is fixed when the burst opens, and later changes of `seq_linear` are ignored.
- R14: While `rst`=1 and after it, `drive_o`=0. Without a strobe, `adv_n`=0 makes no access and drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, loaded when a cycle opens |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side address strobe, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst step request, active low |
| gwr_n | input | 1 | Whole-word write enable, active low |
| bwr_en_n | input | 1 | Byte-write qualifier, active low |
| bstrb_n | input | 4 | Per-lane write strobes, active low, bit i = lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 exclusive-or |
| wdata_i | input | 32 | Write data, captured on the write edge |
| rdata_o | output | 32 | Registered read data, zero when not driven |
| drive_o | output | 1 | Output drive flag |

## Verification
The whole address space is first written with whole-word writes, then read back through processor-strobe reads. This separates addressing errors from pipeline-latency errors. All sixteen byte-strobe masks are then swept, with byte-write enabled and also with it disabled, which separates per-lane gating from the global override. Each of the four base offsets is run in both burst orders, with the order input flipped in the middle of the burst. This separates linear from exclusive-or stepping, checks the wrap and the hold, and shows whether the order was latched. Strobe and enable combinations that should deselect, or should ignore write enables, are followed by read-back of the same address, so a forbidden write shows up at the data port.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_DESEL,
        CY_RSTART,
        CY_WSTART,
        CY_STEP,
        CY_HOLD
    } cyc_e;

    typedef struct packed {
        cyc_e             kind;
        logic [LANES-1:0] wmask;
    } cyc_t;

    function automatic logic [BURST_W-1:0] burst_off(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               lin
    );
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction
endpackage

// File: rtl/psc_burst_seq.sv
module psc_burst_seq
    import psc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_i,
    input  logic          lin_i,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               lin_q;
    logic [BURST_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + BURST_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (load) begin
            base_q <= addr_i;
            cnt_q  <= '0;
            lin_q  <= lin_i;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end

    assign cur_addr = {base_q[AW-1:BURST_W], burst_off(base_q[BURST_W-1:0], cnt_q, lin_q)};
    assign nxt_addr = {base_q[AW-1:BURST_W], burst_off(base_q[BURST_W-1:0], cnt_nx, lin_q)};
endmodule

// File: rtl/psc_cyc_decode.sv
module psc_cyc_decode
    import psc_pkg::*;
(
    input  logic             strb_proc_n,
    input  logic             strb_ctrl_n,
    input  logic             ce_main_n,
    input  logic             ce_hi,
    input  logic             ce_lo_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_en_n,
    input  logic [LANES-1:0] bstrb_n,
    input  logic             active,
    output cyc_t             cyc
);
    logic             proc_go;
    logic             ctrl_go;
    logic             chip_on;
    logic [LANES-1:0] mask;

    always_comb begin
        proc_go = !strb_proc_n && !ce_main_n;
        ctrl_go = !strb_ctrl_n && !proc_go;
        chip_on = !ce_main_n && ce_hi && !ce_lo_n;
        if (!gwr_n)         mask = '1;
        else if (!bwr_en_n) mask = ~bstrb_n;
        else                mask = '0;

        cyc.kind  = CY_IDLE;
        cyc.wmask = '0;
        if (proc_go) begin
            cyc.kind = chip_on ? CY_RSTART : CY_DESEL;
        end else if (ctrl_go) begin
            if (!chip_on) begin
                cyc.kind = CY_DESEL;
            end else begin
                cyc.kind  = (mask != '0) ? CY_WSTART : CY_RSTART;
                cyc.wmask = mask;
            end
        end else if (active) begin
            cyc.kind  = adv_n ? CY_HOLD : CY_STEP;
            cyc.wmask = mask;
        end
    end
endmodule

// File: rtl/psc_lane_array.sv
module psc_lane_array
    import psc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[l])  mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            if (rd_en)  rd_q       <= mem[raddr];
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/psram_cyc_ctl.sv
module psram_cyc_ctl
    import psc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              ce_main_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_en_n,
    input  logic [LANES-1:0]  bstrb_n,
    input  logic              oe_n,
    input  logic              seq_linear,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    cyc_t              cyc;
    logic              active_q;
    logic              start;
    logic [AW-1:0]     cur_addr;
    logic [AW-1:0]     nxt_addr;
    logic [AW-1:0]     acc_addr;
    logic              acc_rd;
    logic [LANES-1:0]  acc_we;
    logic              s1_rd_q;
    logic [AW-1:0]     s1_addr_q;
    logic              out_vld_q;
    logic [DATA_W-1:0] arr_q;

    psc_cyc_decode u_dec (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .ce_main_n   (ce_main_n),
        .ce_hi       (ce_hi),
        .ce_lo_n     (ce_lo_n),
        .adv_n       (adv_n),
        .gwr_n       (gwr_n),
        .bwr_en_n    (bwr_en_n),
        .bstrb_n     (bstrb_n),
        .active      (active_q),
        .cyc         (cyc)
    );

    assign start = (cyc.kind == CY_RSTART) || (cyc.kind == CY_WSTART);

    psc_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .step     (cyc.kind == CY_STEP),
        .addr_i   (addr_i),
        .lin_i    (seq_linear),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    always_comb begin
        if (start)                      acc_addr = addr_i;
        else if (cyc.kind == CY_STEP)   acc_addr = nxt_addr;
        else                            acc_addr = cur_addr;

        acc_rd = ((cyc.kind == CY_RSTART) || (cyc.kind == CY_STEP) || (cyc.kind == CY_HOLD))
                 && (cyc.wmask == '0);

        if ((cyc.kind == CY_WSTART) || (cyc.kind == CY_STEP) || (cyc.kind == CY_HOLD))
            acc_we = cyc.wmask;
        else
            acc_we = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            s1_rd_q   <= 1'b0;
            s1_addr_q <= '0;
            out_vld_q <= 1'b0;
        end else begin
            if (start)                     active_q <= 1'b1;
            else if (cyc.kind == CY_DESEL) active_q <= 1'b0;
            s1_rd_q   <= acc_rd;
            s1_addr_q <= acc_addr;
            out_vld_q <= s1_rd_q && (acc_we == '0);
        end
    end

    psc_lane_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .we    (acc_we),
        .waddr (acc_addr),
        .wdata (wdata_i),
        .rd_en (s1_rd_q),
        .raddr (s1_addr_q),
        .rdata (arr_q)
    );

    assign drive_o = out_vld_q && !oe_n;
    assign rdata_o = drive_o ? arr_q : '0;
endmodule

// File: rtl/psram_cyc_chk.sv
module psram_cyc_chk (
    input logic       clk,
    input logic       rst,
    input logic       strb_proc_n,
    input logic       strb_ctrl_n,
    input logic       ce_main_n,
    input logic       ce_hi,
    input logic       ce_lo_n,
    input logic       gwr_n,
    input logic       bwr_en_n,
    input logic [3:0] bstrb_n,
    input logic       oe_n,
    input logic       drive_o
);
    logic proc_go, ctrl_go, chip_on, wr_req;

    assign proc_go = !strb_proc_n && !ce_main_n;
    assign ctrl_go = !strb_ctrl_n && !proc_go;
    assign chip_on = !ce_main_n && ce_hi && !ce_lo_n;
    assign wr_req  = !gwr_n || (!bwr_en_n && (bstrb_n != 4'hF));

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !drive_o); // R14

    AST_DESEL_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        ((proc_go || ctrl_go) && !chip_on) |=> ##1 !drive_o); // R11

    AST_CTRL_NO_MASTER: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctrl_n && ce_main_n) |=> ##1 !drive_o); // R3

    AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (rst)
        (ctrl_go && chip_on && wr_req) |=> !drive_o); // R10

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ($past(proc_go && chip_on && !rst, 2) && $past(!wr_req && !rst, 1) && !oe_n)
        |-> drive_o); // R8
endmodule

bind psram_cyc_ctl psram_cyc_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .ce_main_n   (ce_main_n),
    .ce_hi       (ce_hi),
    .ce_lo_n     (ce_lo_n),
    .gwr_n       (gwr_n),
    .bwr_en_n    (bwr_en_n),
    .bstrb_n     (bstrb_n),
    .oe_n        (oe_n),
    .drive_o     (drive_o)
);

// File: tb/psram_cyc_ctl_tb_top.sv
module psram_cyc_ctl_tb_top;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          strb_proc_n, strb_ctrl_n, ce_main_n, ce_hi, ce_lo_n, adv_n;
    logic          gwr_n, bwr_en_n, oe_n, seq_linear;
    logic [3:0]    bstrb_n;
    logic [31:0]   wdata_i, rdata_o;
    logic          drive_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [DEPTH];

    always #4 clk = ~clk;

    psram_cyc_ctl #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .adv_n(adv_n), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bstrb_n(bstrb_n),
        .oe_n(oe_n), .seq_linear(seq_linear), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .drive_o(drive_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_en_n = 1'b1; bstrb_n = 4'hF;
        ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] d);
        strb_ctrl_n = 1'b0; gwr_n = 1'b0; bstrb_n = 4'h0; bwr_en_n = 1'b1;
        addr_i = a; wdata_i = d;
        tick();
        model[a] = d;
        quiet();
    endtask

    task automatic wr_bytes(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] m);
        strb_ctrl_n = 1'b0; gwr_n = 1'b1; bwr_en_n = 1'b0; bstrb_n = ~m;
        addr_i = a; wdata_i = d;
        tick();
        for (int l = 0; l < 4; l++)
            if (m[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
        quiet();
    endtask

    task automatic rd_proc(input string tag, input logic [AW-1:0] a);
        strb_proc_n = 1'b0; addr_i = a;
        tick();
        quiet();
        tick();
        check({tag, " drive"}, {31'b0, drive_o}, 32'd1);
        check({tag, " data"}, rdata_o, model[a]);
    endtask

    function automatic logic [1:0] off(input logic [1:0] b, input logic [1:0] n, input logic lin);
        return lin ? (b + n) : (b ^ n);
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        quiet();
        rst = 1'b1; oe_n = 1'b0; seq_linear = 1'b0; addr_i = '0; wdata_i = '0;
        tick(); tick();
        check("R14 drive in reset", {31'b0, drive_o}, 32'd0);
        rst = 1'b0;
        adv_n = 1'b0;
        tick(); tick();
        check("R14 step without burst", {31'b0, drive_o}, 32'd0);
        quiet();

        // R5 whole-word fill, R8 latency on read back
        for (int a = 0; a < DEPTH; a++)
            wr_word(AW'(a), {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'(a) + 8'h3C});
        for (int a = 0; a < DEPTH; a++)
            rd_proc("R5 R8 fill", AW'(a));

        // R6 / R7 byte mask sweep
        for (int m = 0; m < 16; m++) begin
            wr_bytes(AW'(16 + m), 32'hA1B2C3D4 ^ {4{4'(m), 4'(m)}}, 4'(m));
            rd_proc((m == 0) ? "R7 empty mask" : "R6 byte mask", AW'(16 + m));
        end
        // R6 byte qualifier off: no write
        strb_ctrl_n = 1'b0; gwr_n = 1'b1; bwr_en_n = 1'b1; bstrb_n = 4'h0;
        addr_i = 6'd20; wdata_i = 32'hDEADBEEF;
        tick(); quiet();
        rd_proc("R6 qualifier off", 6'd20);
        // R5 global overrides disabled byte strobes
        strb_ctrl_n = 1'b0; gwr_n = 1'b0; bwr_en_n = 1'b1; bstrb_n = 4'hF;
        addr_i = 6'd21; wdata_i = 32'h0BADF00D;
        tick(); model[21] = 32'h0BADF00D; quiet();
        rd_proc("R5 global override", 6'd21);

        // R1 / R2 processor strobe wins and ignores write enables
        strb_proc_n = 1'b0; strb_ctrl_n = 1'b0; gwr_n = 1'b0; bwr_en_n = 1'b0;
        bstrb_n = 4'h0; addr_i = 6'd40; wdata_i = 32'h12345678;
        tick(); quiet(); tick();
        check("R1 read despite write enables drive", {31'b0, drive_o}, 32'd1);
        check("R2 processor strobe precedence", rdata_o, model[40]);

        // R3 master enable off: controller strobe deselects, no write
        ce_main_n = 1'b1; strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr_i = 6'd41; wdata_i = 32'hFFFF0000;
        tick(); quiet(); tick();
        check("R3 deselect drive", {31'b0, drive_o}, 32'd0);
        ce_main_n = 1'b1; strb_proc_n = 1'b0; addr_i = 6'd41;
        tick(); quiet(); tick();
        check("R3 blocked processor strobe", {31'b0, drive_o}, 32'd0);
        rd_proc("R3 no write", 6'd41);

        // R4 secondary enables
        ce_hi = 1'b0; strb_proc_n = 1'b0; addr_i = 6'd42;
        tick(); quiet(); tick();
        check("R4 ce_hi low deselect", {31'b0, drive_o}, 32'd0);
        ce_lo_n = 1'b1; strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr_i = 6'd42; wdata_i = 32'h0;
        tick(); quiet(); tick();
        check("R4 ce_lo_n high deselect", {31'b0, drive_o}, 32'd0);
        rd_proc("R4 no write", 6'd42);

        // R9 asynchronous output enable
        rd_proc("R9 setup", 6'd7);
        oe_n = 1'b1; #1;
        check("R9 oe off drive", {31'b0, drive_o}, 32'd0);
        check("R9 oe off data", rdata_o, 32'd0);
        oe_n = 1'b0; #1;
        check("R9 oe on drive", {31'b0, drive_o}, 32'd1);

        // R10 write in a held burst mutes output
        rd_proc("R10 setup", 6'd8);
        gwr_n = 1'b0; wdata_i = 32'hCAFEF00D;
        tick();
        model[8] = 32'hCAFEF00D;
        check("R10 write mutes drive", {31'b0, drive_o}, 32'd0);
        quiet();
        rd_proc("R10 held write landed", 6'd8);

        // R11 single-cycle deselect
        rd_proc("R11 setup", 6'd9);
        strb_ctrl_n = 1'b0; ce_hi = 1'b0;
        tick(); quiet();
        check("R11 still driving", {31'b0, drive_o}, 32'd1);
        check("R11 data", rdata_o, model[9]);
        tick();
        check("R11 off after one clock", {31'b0, drive_o}, 32'd0);

        // R12 / R13 burst orders, wrap, hold, latched order
        for (int lin = 0; lin < 2; lin++) begin
            for (int b = 0; b < 4; b++) begin
                seq_linear = 1'(lin);
                strb_proc_n = 1'b0; addr_i = AW'(32 + b);
                tick(); quiet();
                seq_linear = ~1'(lin);
                adv_n = 1'b0;
                for (int i = 1; i <= 3; i++) begin
                    tick();
                    check("R12 burst step", rdata_o,
                          model[{4'b1000, off(2'(b), 2'(i - 1), 1'(lin))}]);
                end
                adv_n = 1'b1; tick();
                check("R12 last beat", rdata_o, model[{4'b1000, off(2'(b), 2'd3, 1'(lin))}]);
                adv_n = 1'b0; tick();
                check("R13 hold address", rdata_o, model[{4'b1000, off(2'(b), 2'd3, 1'(lin))}]);
                adv_n = 1'b1; tick();
                check("R12 wrap", rdata_o, model[{4'b1000, off(2'(b), 2'd0, 1'(lin))}]);
                quiet();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule